// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a CPU-side request port and a byte-addressable memory. Each alias window is 32 MB, and every aligned word in it stands for one bit of a smaller target region. A CPU read of an alias word returns that one bit as 0 or 1. A CPU write to an alias word changes only that bit. To do this, the bridge reads the target location, sets or clears the bit, and writes the result back. No other master may access memory between the read and the write.

The number of windows is a parameter, and so is each window's alias base and target base. By default there are two windows. Alias base 0x22000000 maps to target base 0x20000000, and alias base 0x42000000 maps to target base 0x40000000. The bridge takes one request at a time. It holds `ready_o` low until the request has finished, and it marks completion with a one-cycle `done_o` pulse. On the memory side it drives a request, waits for a grant, and then waits for a response strobe. The memory port uses byte, halfword and word sizes with little-endian byte lanes.

Top module: `bitband_bridge`

## Requirements
- R1: `ready_o` is high only when no request is in progress. The bridge accepts a request when `req_i` and `ready_o` are both high at a clock edge, and `ready_o` is low on the cycle after that. Each request ends with `done_o` high for exactly one cycle, and `ready_o` returns high on the cycle after `done_o`.
- R2: Window selection and target address:
  - An address is inside window k when its bits above bit 24 equal those of alias base k. The lowest-numbered matching window is used.
  - The target address is target base k ORed with (alias offset >> 5), where the alias offset is the low 25 bits of the address.
  - The target address is forced even for a halfword access and forced to a multiple of 4 for a word access.
  - `mem_size_o` repeats the request size: 0 is byte, 1 is halfword, 2 or 3 is word.
- R3: Bit selection and byte lanes:
  - The bit number within the accessed unit is (offset >> 2), kept to 3 bits for a byte, 4 bits for a halfword and 5 bits for a word.
  - Lanes are little-endian. A byte uses lane `mem_addr_o[1:0]`, and `mem_be_o` has that single bit set. A halfword uses lanes 2*`mem_addr_o[1]` and the lane above it. A word uses all four lanes.
- R4: A read makes exactly one memory read and no memory write. While `done_o` is high, `rdata_o` is 1 if the selected bit is set and 0 if it is clear, and bits 31:1 of `rdata_o` are zero.
- R5: A write makes one memory read and then one memory write, to the same address and with the same size. The selected bit becomes `wdata_i[0]`, and every other bit in the enabled lanes keeps the value that was read.
- R6: Bits 31:1 of `wdata_i` have no effect on memory.
- R7: `mem_lock_o` is high from the read request of a write sequence until that sequence's write completes. It is high whenever a memory write is requested, and it is low during read-only requests and while idle.
- R8: A request that falls in no window makes no memory access. It still completes with a `done_o` pulse, and `rdata_o` is 0.
- R9: While in reset, and on the first cycle after reset, `ready_o` is 1 and `done_o`, `mem_req_o` and `mem_lock_o` are 0.
- R10: Once `mem_req_o` is raised, it stays high with `mem_addr_o` and `mem_we_o` unchanged until `mem_gnt_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU request |
| we_i | input | 1 | CPU request is a write |
| addr_i | input | 32 | CPU alias address |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| wdata_i | input | 32 | Write data; only bit 0 is used |
| ready_o | output | 1 | Bridge idle and able to accept a request |
| done_o | output | 1 | Request completed (one-cycle pulse) |
| rdata_o | output | 32 | Read result, valid while `done_o` is high |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_lock_o | output | 1 | Memory is held for an atomic read-modify-write |
| mem_addr_o | output | 32 | Memory target address |
| mem_size_o | output | 2 | Memory access size |
| mem_be_o | output | 4 | Memory byte-lane enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory grant for the current request |
| mem_rvalid_i | input | 1 | Memory response strobe |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_rvalid_i` |

## Verification
The assertions check the following on every cycle:
- the ready and done handshake;
- the request-hold rule toward memory;
- the lock being held during every write;
- target address alignment for each size;
- the number of byte lanes enabled for each size.

Some behaviour can only be shown by the bench scenarios, which use a memory model that stalls grants. These scenarios check:
- the exact target address and bit chosen for each alias offset in both windows;
- that the other bits of each target word are preserved after a sweep of writes, including writes whose upper data bits are junk;
- the read-back values under a different access size;
- that out-of-window requests never reach memory.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned POS_W  = $clog2(DATA_W);
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } state_e;
endpackage

// File: rtl/bitband_decode.sv
module bitband_decode
  import bitband_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned WIN_W = 25,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [POS_W-1:0]  bit_pos_o
);
  localparam logic [ADDR_W-1:0] WIN_MASK = (ADDR_W'(1) << WIN_W) - ADDR_W'(1);
  localparam int unsigned BIT_SHIFT = 5;

  logic [NUM_REGIONS-1:0] hit_vec;
  logic [ADDR_W-1:0]      off, raw;
  logic [POS_W-1:0]       bn, bn_m, lane_base;
  logic [1:0]             lane;

  assign off = addr_i & WIN_MASK;
  assign bn  = off[2+:POS_W];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    assign hit_vec[g] = (addr_i[ADDR_W-1:WIN_W] == ALIAS_BASE[g][ADDR_W-1:WIN_W]);
  end

  // lowest index wins: it is assigned last
  always_comb begin
    hit_o = 1'b0;
    raw   = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hit_vec[r]) begin
        hit_o = 1'b1;
        raw   = TARGET_BASE[r] | (off >> BIT_SHIFT);
      end
    end
  end

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: begin
        tgt_addr_o = raw;
        bn_m       = {2'b00, bn[2:0]};
        lane       = raw[1:0];
      end
      SZ_HALF: begin
        tgt_addr_o = {raw[ADDR_W-1:1], 1'b0};
        bn_m       = {1'b0, bn[3:0]};
        lane       = {raw[1], 1'b0};
      end
      default: begin
        tgt_addr_o = {raw[ADDR_W-1:2], 2'b00};
        bn_m       = bn;
        lane       = 2'b00;
      end
    endcase
  end

  assign lane_base = {lane, 3'b000};
  assign bit_pos_o = lane_base + bn_m;
endmodule

// File: rtl/bitband_lane.sv
module bitband_lane
  import bitband_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [1:0]        addr_lo_i,
  input  logic [POS_W-1:0]  bit_pos_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [BE_W-1:0]   be_o,
  output logic              bit_o,
  output logic [DATA_W-1:0] merged_o
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: be_o = BE_W'(1) << addr_lo_i;
      SZ_HALF: be_o = BE_W'(3) << {addr_lo_i[1], 1'b0};
      default: be_o = '1;
    endcase
  end

  assign mask     = DATA_W'(1) << bit_pos_i;
  assign bit_o    = rd_word_i[bit_pos_i];
  assign merged_o = set_i ? (rd_word_i | mask) : (rd_word_i & ~mask);
endmodule

// File: rtl/bitband_fsm.sv
module bitband_fsm
  import bitband_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hit_i,
  input  logic we_i,
  input  logic gnt_i,
  input  logic rvalid_i,
  output logic ready_o,
  output logic accept_o,
  output logic load_o,
  output logic done_o,
  output logic rmw_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic lock_o
);
  state_e state_q, state_d;
  logic   we_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o & req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i)    state_d = hit_i ? ST_RD_REQ : ST_RESP;
      ST_RD_REQ:  if (gnt_i)    state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (rvalid_i) state_d = we_q ? ST_WR_REQ : ST_RESP;
      ST_WR_REQ:  if (gnt_i)    state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (rvalid_i) state_d = ST_RESP;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) we_q <= we_i;
    end
  end

  assign load_o    = (state_q == ST_RD_WAIT) & rvalid_i;
  assign done_o    = (state_q == ST_RESP);
  assign rmw_o     = we_q;
  assign mem_req_o = (state_q == ST_RD_REQ) | (state_q == ST_WR_REQ);
  assign mem_we_o  = (state_q == ST_WR_REQ);
  assign lock_o    = we_q & ((state_q == ST_RD_REQ) | (state_q == ST_RD_WAIT) |
                             (state_q == ST_WR_REQ) | (state_q == ST_WR_WAIT));
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bitband_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned WIN_W = 25,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i
);
  logic              dec_hit, accept, load, rmw, lane_bit;
  logic [ADDR_W-1:0] dec_tgt, tgt_q;
  logic [POS_W-1:0]  dec_pos, pos_q;
  logic [1:0]        size_q;
  logic              wbit_q, hit_q;
  logic [DATA_W-1:0] rd_q, merged;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[31:1];

  bitband_decode #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .WIN_W(WIN_W),
    .ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE)
  ) u_decode (
    .addr_i(addr_i), .size_i(size_i),
    .hit_o(dec_hit), .tgt_addr_o(dec_tgt), .bit_pos_o(dec_pos)
  );

  bitband_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .hit_i(dec_hit), .we_i(we_i),
    .gnt_i(mem_gnt_i), .rvalid_i(mem_rvalid_i),
    .ready_o(ready_o), .accept_o(accept), .load_o(load), .done_o(done_o), .rmw_o(rmw),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .lock_o(mem_lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= '0;
      pos_q  <= '0;
      size_q <= '0;
      wbit_q <= 1'b0;
      hit_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (accept) begin
        tgt_q  <= dec_tgt;
        pos_q  <= dec_pos;
        size_q <= size_i;
        wbit_q <= wdata_i[0];
        hit_q  <= dec_hit;
      end
      if (load) rd_q <= mem_rdata_i;
    end
  end

  bitband_lane u_lane (
    .size_i(size_q), .addr_lo_i(tgt_q[1:0]), .bit_pos_i(pos_q), .set_i(wbit_q),
    .rd_word_i(rd_q), .be_o(mem_be_o), .bit_o(lane_bit), .merged_o(merged)
  );

  assign mem_addr_o  = tgt_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = mem_we_o ? merged : '0;
  assign rdata_o     = (done_o && hit_q && !rmw) ? {31'b0, lane_bit} : 32'b0;
endmodule

// File: rtl/bitband_bridge_sva.sv
module bitband_bridge_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        ready_o,
  input logic        done_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        mem_lock_o,
  input logic        mem_gnt_i,
  input logic [31:0] mem_addr_o,
  input logic [1:0]  mem_size_o,
  input logic [3:0]  mem_be_o
);
  assert_busy_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_i |=> !ready_o);
  assert_idle_no_mem_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o && !done_o);
  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o);
  assert_half_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_size_o == 2'd1 |-> !mem_addr_o[0]);
  assert_word_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_size_o[1] |-> mem_addr_o[1:0] == 2'b00);
  assert_byte_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_size_o == 2'd0 |-> $countones(mem_be_o) == 1);
  assert_half_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_size_o == 2'd1 |-> $countones(mem_be_o) == 2);
  assert_word_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_size_o[1] |-> mem_be_o == 4'hF);
  assert_write_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_lock_o);
  assert_idle_unlocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_lock_o);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

bind bitband_bridge bitband_bridge_sva u_sva (.*);

// File: tb/bitband_bridge_test.sv
module bitband_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_i, we_i;
  logic [31:0] addr_i, wdata_i;
  logic [1:0]  size_i;
  logic        ready_o, done_o;
  logic [31:0] rdata_o;
  logic        mem_req_o, mem_we_o, mem_lock_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [1:0]  mem_size_o;
  logic [3:0]  mem_be_o;
  logic        mem_gnt_i;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;

  int checks = 0;
  int errors = 0;
  int mem_acc = 0;
  int lock_err = 0;
  logic [31:0] last_addr;
  logic [1:0]  last_size;
  logic [3:0]  last_be;
  logic [7:0]  cyc;
  logic [31:0] mem [0:63];
  logic [7:0]  sh  [0:255];

  always #5 clk_i = ~clk_i;

  bitband_bridge uut (.*);

  assign mem_gnt_i = mem_req_o & (cyc[2:0] != 3'd3);

  always @(posedge clk_i) begin
    cyc          <= cyc + 8'd1;
    mem_rvalid_i <= 1'b0;
    if (mem_req_o && mem_gnt_i) begin
      mem_rvalid_i <= 1'b1;
      mem_acc      <= mem_acc + 1;
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[{mem_addr_o[30], mem_addr_o[6:2]}][8*b +: 8] <= mem_wdata_o[8*b +: 8];
        if (!mem_lock_o) lock_err <= lock_err + 1;
        last_addr <= mem_addr_o;
        last_size <= mem_size_o;
        last_be   <= mem_be_o;
      end else begin
        mem_rdata_i <= mem[{mem_addr_o[30], mem_addr_o[6:2]}];
      end
    end
  end

  function automatic logic [31:0] seed_word(input int w);
    return 32'h6B2F_91D4 ^ (32'(w) * 32'h0101_0301);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [31:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    rd = rdata_o;
  endtask

  task automatic shadow_set(input int r, input int off, input logic v);
    sh[r*128 + (off >> 5)][(off >> 2) & 7] = v;
  endtask

  task automatic cmp_mem(input string req);
    for (int w = 0; w < 64; w++)
      chk(mem[w] == {sh[4*w+3], sh[4*w+2], sh[4*w+1], sh[4*w]}, req, mem[w],
          {sh[4*w+3], sh[4*w+2], sh[4*w+1], sh[4*w]});
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int acc0;
    cyc = '0; mem_rdata_i = '0; mem_rvalid_i = 1'b0;
    req_i = 0; we_i = 0; addr_i = '0; size_i = '0; wdata_i = '0;
    for (int w = 0; w < 64; w++) begin
      mem[w] = seed_word(w);
      for (int b = 0; b < 4; b++) sh[4*w+b] = seed_word(w) >> (8*b);
    end
    rst_ni = 1'b0;
    #1;
    chk(ready_o && !done_o && !mem_req_o && !mem_lock_o, "R9 in reset",
        {28'b0, ready_o, done_o, mem_req_o, mem_lock_o}, 32'h8);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o && !done_o && !mem_req_o && !mem_lock_o, "R9 after reset",
        {28'b0, ready_o, done_o, mem_req_o, mem_lock_o}, 32'h8);

    // R1/R7: busy and lock during a write, release afterwards
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 32'h2200_0040; size_i = 2'd0; wdata_i = 32'h1;
    @(negedge clk_i);
    req_i = 0;
    chk(!ready_o, "R1 busy", {31'b0, ready_o}, 0);
    chk(mem_lock_o, "R7 lock during rmw", {31'b0, mem_lock_o}, 1);
    while (!done_o) @(negedge clk_i);
    shadow_set(0, 32'h40, 1'b1);
    @(negedge clk_i);
    chk(!done_o && ready_o, "R1 done pulse", {30'b0, done_o, ready_o}, 1);
    chk(!mem_lock_o, "R7 lock released", {31'b0, mem_lock_o}, 0);

    // R7: read-only keeps lock low
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = 32'h2200_0040; size_i = 2'd2;
    @(negedge clk_i);
    req_i = 0;
    chk(!mem_lock_o, "R7 no lock on read", {31'b0, mem_lock_o}, 0);
    while (!done_o) @(negedge clk_i);
    chk(rdata_o == 32'd1, "R4 read after write", rdata_o, 1);

    // R5/R6: write sweep with junk upper data bits, sizes rotating
    for (int r = 0; r < 2; r++)
      for (int off = 0; off < 4096; off += 4) begin
        logic v;
        v = 1'(((off >> 2) ^ (off >> 7) ^ r) & 1);
        do_op(1'b1, (r ? 32'h4200_0000 : 32'h2200_0000) + 32'(off), 2'((off >> 2) % 3),
              {32'(off) * 32'h9E37_79B1} & 32'hFFFF_FFFE | 32'(v), rd);
        shadow_set(r, off, v);
      end
    cmp_mem("R5 R6 memory after writes");

    // R3/R4: read sweep with a different size
    for (int r = 0; r < 2; r++)
      for (int off = 0; off < 4096; off += 4) begin
        logic [31:0] exp;
        exp = {31'b0, sh[r*128 + (off >> 5)][(off >> 2) & 7]};
        do_op(1'b0, (r ? 32'h4200_0000 : 32'h2200_0000) + 32'(off), 2'(((off >> 2) + 1) % 3),
              32'hFFFF_FFFF, rd);
        chk(rd == exp, "R3 R4 read bit", rd, exp);
      end
    cmp_mem("R4 reads leave memory");

    // R2/R3: target address, size and lanes (offset 0x64: byte 3, bit 25)
    do_op(1'b1, 32'h2200_0064, 2'd2, 32'h1, rd); shadow_set(0, 32'h64, 1'b1);
    chk(last_addr == 32'h2000_0000 && last_size == 2'd2, "R2 word target", last_addr, 32'h2000_0000);
    chk(last_be == 4'hF, "R3 word lanes", {28'b0, last_be}, 32'hF);
    do_op(1'b1, 32'h2200_0064, 2'd1, 32'h0, rd); shadow_set(0, 32'h64, 1'b0);
    chk(last_addr == 32'h2000_0002 && last_size == 2'd1, "R2 half target", last_addr, 32'h2000_0002);
    chk(last_be == 4'b1100, "R3 half lanes", {28'b0, last_be}, 32'hC);
    do_op(1'b1, 32'h2200_0064, 2'd0, 32'h1, rd); shadow_set(0, 32'h64, 1'b1);
    chk(last_addr == 32'h2000_0003 && last_size == 2'd0, "R2 byte target", last_addr, 32'h2000_0003);
    chk(last_be == 4'b1000, "R3 byte lane", {28'b0, last_be}, 32'h8);
    do_op(1'b1, 32'h4200_0064, 2'd3, 32'h0, rd); shadow_set(1, 32'h64, 1'b0);
    chk(last_addr == 32'h4000_0000 && last_size == 2'd3, "R2 second window", last_addr, 32'h4000_0000);
    cmp_mem("R5 targeted writes");

    // R8: out-of-window requests
    acc0 = mem_acc;
    do_op(1'b0, 32'h3000_0010, 2'd2, 32'h0, rd);
    chk(rd == 32'd0, "R8 miss read data", rd, 0);
    do_op(1'b1, 32'h21FF_FFFC, 2'd0, 32'h1, rd);
    @(negedge clk_i);
    chk(mem_acc == acc0, "R8 no memory access", 32'(mem_acc), 32'(acc0));
    cmp_mem("R8 memory untouched");

    chk(lock_err == 0, "R7 writes under lock", 32'(lock_err), 0);
    summary();
    $finish;
  end
endmodule